// File: doc/BRIEF.md
# Serial Port Bit-Rate Tick Generator

This block produces the two timing strobes that a serial transmitter and receiver need. Both strobes are single-cycle enable pulses in the system clock domain. The first is a sampling tick that paces receiver oversampling. The second is a bit-rate tick that marks each bit period. The block picks one of several source events, divides them by a programmable 16-bit factor to form the sampling tick, and then divides that tick by 16 or by 8 to form the bit-rate tick.

The source can be every system clock, every eighth system clock from a fixed prescaler, or each rising edge of an external clock pin. The pin is synchronised into the system clock domain before its edges are detected. In synchronous mode the oversampling stage is skipped, so the bit-rate tick follows the sampling tick one for one. The resulting rate is source_rate / (8 × (2 − overSel) × divisor). For example, a 3.6864 MHz source with a divisor of 6 and 16x oversampling gives exactly 38400 bit/s, and a 5 MHz source with a divisor of 8 gives 39062.5 bit/s, about 1.7% fast. The highest rate is one eighth of the system clock, reached with the system clock as source, 8x oversampling and a divisor of 1.

Top module: `brg_top`

## Requirements
- R1: While rstN is low, and on the first sample after it is released, sampleTick and baudTick are both 0.
- R2: With srcSel = 0 (system clock), a divisor N ≥ 1 and stable settings, sampleTick pulses once every N system clocks. N = 1 gives a pulse on every cycle.
- R3: With syncMode = 0, baudTick pulses once every 16 sampleTicks when overSel = 0 and once every 8 when overSel = 1. With srcSel = 0 this gives bit periods of 16·N and 8·N system clocks, so 96 clocks for N = 6 and 128 clocks for N = 8 at 16x.
- R4: srcSel = 1 uses a fixed divide-by-8 prescaler as the source, so the sampleTick period is 8·N system clocks.
- R5: srcSel = 2 is reserved and produces no sampleTick and no baudTick.
- R6: srcSel = 3 counts each rising edge of extClkPin, after a two-stage synchroniser, as one source event. A pin that toggles every 3 system clocks gives a sampleTick period of 6·N clocks.
- R7: A divisor of 0 stops both tick outputs for as long as it is held.
- R8: With syncMode = 1 the oversampling stage is bypassed, and baudTick pulses in exactly the cycles in which sampleTick pulses.
- R9: Any change of srcSel, divisor, overSel or syncMode clears all counters. With srcSel = 0, the first sampleTick is high after the (N+1)-th rising clock edge counted from the edge that first sees the new setting. The first baudTick follows after one full oversampling group.
- R10: baudTick is never high in a cycle in which sampleTick is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| extClkPin | input | 1 | External source clock, asynchronous to clk |
| srcSel | input | 2 | Source: 0 system clock, 1 prescaled by 8, 2 reserved, 3 external pin |
| divisor | input | 16 | Divide factor for the sampling tick; 0 halts ticks |
| overSel | input | 1 | 0 selects 16x oversampling, 1 selects 8x |
| syncMode | input | 1 | 1 bypasses the oversampling divider |
| sampleTick | output | 1 | One-cycle sampling strobe |
| baudTick | output | 1 | One-cycle bit-rate strobe |

## Verification
The assertions assume that the configuration inputs change only between measurements, and that an external clock stays well below the system clock rate, with each phase longer than one system clock. The bench drives the pin with a square wave that toggles every three clocks, which is six times slower than the system clock. It changes settings only on falling clock edges. It measures tick spacing only after the first tick that follows a change, except in the restart scenario, which measures the first tick on purpose.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int DIV_W      = 16;
  localparam int PRESCALE   = 8;
  localparam int OVS_HI     = 16;
  localparam int OVS_LO     = 8;
  localparam int SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    SRC_SYS      = 2'd0,
    SRC_PRESCALE = 2'd1,
    SRC_NONE     = 2'd2,
    SRC_EXT      = 2'd3
  } srcKind_t;

  typedef struct packed {
    logic srcEn;    // one source event this cycle
    logic restart;  // configuration changed, clear all counters
  } ctrlStrobes_t;
endpackage

// File: rtl/brg_ctrl.sv
module brg_ctrl
  import brg_pkg::*;
#(
  parameter int DivW      = DIV_W,
  parameter int Prescale  = PRESCALE,
  parameter int SyncDepth = SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extClkPin,
  input  logic [1:0]        srcSel,
  input  logic [DivW-1:0]   divisor,
  input  logic              overSel,
  input  logic              syncMode,
  output ctrlStrobes_t      strobes
);
  localparam int PreW = (Prescale > 1) ? $clog2(Prescale) : 1;
  localparam int CfgW = 2 + DivW + 2;

  // external pin synchroniser chain
  logic [SyncDepth-1:0] syncChain;
  logic                 extLast;
  logic                 extEdge;

  genvar gi;
  generate
    for (gi = 0; gi < SyncDepth; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= extClkPin;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[gi] <= 1'b0;
          else       syncChain[gi] <= syncChain[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) extLast <= 1'b0;
    else       extLast <= syncChain[SyncDepth-1];
  end

  assign extEdge = syncChain[SyncDepth-1] & ~extLast;

  // configuration change detection
  logic [CfgW-1:0] cfgNow;
  logic [CfgW-1:0] cfgQ;
  logic            cfgChanged;

  assign cfgNow     = {srcSel, divisor, overSel, syncMode};
  assign cfgChanged = (cfgNow != cfgQ);

  always_ff @(posedge clk) begin
    if (!rstN) cfgQ <= '0;
    else       cfgQ <= cfgNow;
  end

  // fixed prescaler
  logic [PreW-1:0] preCnt;
  logic            preHit;

  assign preHit = (preCnt == PreW'(Prescale - 1));

  always_ff @(posedge clk) begin
    if (!rstN || cfgChanged) preCnt <= '0;
    else if (preHit)         preCnt <= '0;
    else                     preCnt <= preCnt + 1'b1;
  end

  // source multiplexer
  logic srcRaw;
  always_comb begin
    unique case (srcKind_t'(srcSel))
      SRC_SYS:      srcRaw = 1'b1;
      SRC_PRESCALE: srcRaw = preHit;
      SRC_EXT:      srcRaw = extEdge;
      default:      srcRaw = 1'b0;
    endcase
  end

  assign strobes.restart = cfgChanged;
  assign strobes.srcEn   = srcRaw & ~cfgChanged;
endmodule

// File: rtl/brg_datapath.sv
module brg_datapath
  import brg_pkg::*;
#(
  parameter int DivW  = DIV_W,
  parameter int OvsHi = OVS_HI,
  parameter int OvsLo = OVS_LO
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobes_t    strobes,
  input  logic [DivW-1:0] divisor,
  input  logic            overSel,
  input  logic            syncMode,
  output logic            sampleTick,
  output logic            baudTick
);
  localparam int OvW = $clog2(OvsHi);

  logic [DivW-1:0] divCnt;
  logic            divActive;
  logic            sampleHit;

  assign divActive = (divisor != '0);
  assign sampleHit = strobes.srcEn & divActive & (divCnt == divisor - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN || strobes.restart || !divActive) divCnt <= '0;
    else if (sampleHit)                         divCnt <= '0;
    else if (strobes.srcEn)                     divCnt <= divCnt + 1'b1;
  end

  // oversampling stage
  logic [OvW-1:0] ovCnt;
  logic [OvW-1:0] ovLast;
  logic           ovHit;

  assign ovLast = overSel ? OvW'(OvsLo - 1) : OvW'(OvsHi - 1);
  assign ovHit  = sampleHit & (ovCnt == ovLast);

  always_ff @(posedge clk) begin
    if (!rstN || strobes.restart) ovCnt <= '0;
    else if (ovHit)               ovCnt <= '0;
    else if (sampleHit)           ovCnt <= ovCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleTick <= 1'b0;
      baudTick   <= 1'b0;
    end else begin
      sampleTick <= sampleHit;
      baudTick   <= syncMode ? sampleHit : ovHit;
    end
  end
endmodule

// File: rtl/brg_top.sv
module brg_top
  import brg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        extClkPin,
  input  logic [1:0]  srcSel,
  input  logic [15:0] divisor,
  input  logic        overSel,
  input  logic        syncMode,
  output logic        sampleTick,
  output logic        baudTick
);
  ctrlStrobes_t strobes;

  brg_ctrl #(
    .DivW(DIV_W), .Prescale(PRESCALE), .SyncDepth(SYNC_DEPTH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .extClkPin(extClkPin), .srcSel(srcSel),
    .divisor(divisor), .overSel(overSel), .syncMode(syncMode),
    .strobes(strobes)
  );

  brg_datapath #(
    .DivW(DIV_W), .OvsHi(OVS_HI), .OvsLo(OVS_LO)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .divisor(divisor),
    .overSel(overSel), .syncMode(syncMode),
    .sampleTick(sampleTick), .baudTick(baudTick)
  );
endmodule

// File: rtl/brg_checker.sv
module brg_checker (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  srcSel,
  input logic [15:0] divisor,
  input logic        syncMode,
  input logic        sampleTick,
  input logic        baudTick
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rstN |=> !sampleTick && !baudTick); // R1
  AST_PRESCALE_SPARSE: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == 2'd1 && sampleTick) |=> !sampleTick); // R4
  AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == 2'd2) |=> !sampleTick && !baudTick); // R5
  AST_ZERO_DIV_HALT: assert property (@(posedge clk) disable iff (!rstN)
    (divisor == 16'd0) |=> !sampleTick && !baudTick); // R7
  AST_SYNC_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    ($past(syncMode) && sampleTick) |-> baudTick); // R8
  AST_BAUD_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    baudTick |-> sampleTick); // R10
endmodule

bind brg_top brg_checker u_chk (
  .clk(clk), .rstN(rstN), .srcSel(srcSel), .divisor(divisor),
  .syncMode(syncMode), .sampleTick(sampleTick), .baudTick(baudTick)
);

// File: tb/brg_top_tb.sv
module brg_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        extClkPin = 1'b0;
  logic [1:0]  srcSel = 2'd0;
  logic [15:0] divisor = 16'd0;
  logic        overSel = 1'b0;
  logic        syncMode = 1'b0;
  logic        sampleTick;
  logic        baudTick;
  logic        extRun = 1'b0;
  int total = 0;
  int bad = 0;
  int orphanBaud = 0;

  brg_top u_dut (
    .clk(clk), .rstN(rstN), .extClkPin(extClkPin), .srcSel(srcSel),
    .divisor(divisor), .overSel(overSel), .syncMode(syncMode),
    .sampleTick(sampleTick), .baudTick(baudTick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // external square wave, toggles every 3 clocks
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      if (extRun) extClkPin = ~extClkPin;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // count edges until the chosen tick is high; 0 if limit reached
  task automatic waitTick(input bit useBaud, input int limit, output int cnt);
    cnt = 0;
    for (int i = 1; i <= limit; i++) begin
      @(posedge clk); #1;
      if (baudTick && !sampleTick) orphanBaud++;
      if (useBaud ? baudTick : sampleTick) begin
        cnt = i;
        return;
      end
    end
  endtask

  task automatic period(input bit useBaud, output int p);
    int dummy;
    waitTick(useBaud, 20000, dummy);
    waitTick(useBaud, 20000, p);
  endtask

  task automatic setCfg(input logic [1:0] s, input int d, input logic o, input logic y);
    @(negedge clk);
    srcSel = s; divisor = 16'(d); overSel = o; syncMode = y;
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R1 sample in reset", int'(sampleTick), 0);
    check("R1 baud in reset", int'(baudTick), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 sample after release", int'(sampleTick), 0);
  endtask

  task automatic testSysClock();
    int p;
    setCfg(2'd0, 6, 1'b0, 1'b0);
    period(1'b0, p); check("R2 sample N=6", p, 6);
    period(1'b1, p); check("R3 baud N=6 x16", p, 96);
    setCfg(2'd0, 8, 1'b0, 1'b0);
    period(1'b1, p); check("R3 baud N=8 x16", p, 128);
    setCfg(2'd0, 8, 1'b1, 1'b0);
    period(1'b1, p); check("R3 baud N=8 x8", p, 64);
    setCfg(2'd0, 1, 1'b1, 1'b0);
    period(1'b0, p); check("R2 sample N=1", p, 1);
    period(1'b1, p); check("R3 max rate clk/8", p, 8);
  endtask

  task automatic testPrescale();
    int p;
    setCfg(2'd1, 3, 1'b1, 1'b0);
    period(1'b0, p); check("R4 sample prescaled", p, 24);
    period(1'b1, p); check("R4 baud prescaled", p, 192);
  endtask

  task automatic testReserved();
    int c;
    setCfg(2'd2, 2, 1'b1, 1'b0);
    waitTick(1'b0, 600, c); check("R5 no sample on code 2", c, 0);
    setCfg(2'd2, 2, 1'b1, 1'b1);
    waitTick(1'b1, 300, c); check("R5 no baud on code 2", c, 0);
  endtask

  task automatic testExternal();
    int p;
    extRun = 1'b1;
    setCfg(2'd3, 4, 1'b0, 1'b0);
    period(1'b0, p); check("R6 ext sample", p, 24);
    period(1'b1, p); check("R6 ext baud", p, 384);
    extRun = 1'b0;
  endtask

  task automatic testZeroDiv();
    int c;
    setCfg(2'd0, 0, 1'b1, 1'b0);
    waitTick(1'b0, 500, c); check("R7 divisor 0 stops sample", c, 0);
    setCfg(2'd0, 0, 1'b1, 1'b1);
    waitTick(1'b1, 300, c); check("R7 divisor 0 stops baud", c, 0);
  endtask

  task automatic testSync();
    int p;
    setCfg(2'd0, 5, 1'b0, 1'b1);
    period(1'b1, p); check("R8 sync baud period", p, 5);
    check("R8 baud with sample", int'(sampleTick), 1);
  endtask

  task automatic testRestart();
    int c;
    setCfg(2'd0, 5, 1'b1, 1'b0);
    repeat (37) @(negedge clk);
    setCfg(2'd0, 3, 1'b1, 1'b0);
    waitTick(1'b0, 100, c); check("R9 first sample after change", c, 4);
    setCfg(2'd0, 7, 1'b1, 1'b0);
    repeat (30) @(negedge clk);
    setCfg(2'd0, 3, 1'b1, 1'b0);
    waitTick(1'b1, 200, c); check("R9 first baud after change", c, 25);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    testReset();
    testSysClock();
    testPrescale();
    testReserved();
    testExternal();
    testZeroDiv();
    testSync();
    testRestart();
    check("R10 baud without sample", orphanBaud, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule